// File: doc/BRIEF.md
# Outbound Mailbox Descriptor Ring Engine

This block runs the transmit side of a message mailbox. Software builds 32-byte descriptors in a small local descriptor store. Each descriptor holds a source buffer address, a mailbox number, an attribute word and a byte count. Software then announces each new descriptor by writing the mode register with its one-shot enqueue bit set. The engine keeps an enqueue slot and a dequeue slot. Whenever the two differ and the unit is enabled, it reads the descriptor at the dequeue slot and presents one transfer request on a valid/ready output. It then waits for a completion pulse from the transfer side, steps the dequeue slot and records what happened in sticky status flags.

The ring length is programmed as a code equal to log2(entries) minus one, so code 0 gives two entries. The length is capped by the descriptor store the block is built with. Both slots wrap to the start of the ring after its last entry. One entry is always kept free, so the ring counts as full when stepping the enqueue slot would make it equal to the dequeue slot. The two pointer registers read back as byte offsets from the ring base, in steps of 32 bytes. An interrupt output combines the sticky flags with per-flag enables held in the mode register. The serial link and the movement of message data are outside the block.

Top module: `obmsg_ring_engine`

## Requirements
- R1: After reset the mode register reads 0x00B20000 (unit off, size code 0, interrupt enables for flags 0x80/0x20/0x10/0x02). Status, dequeue pointer and enqueue pointer read 0, and req_valid_o and irq_o are low.
- R2: Each request carries these descriptor fields:
  - word 1 as the source address;
  - word 2 bits [1:0] as the mailbox;
  - word 3 bits [17:2] as the destination ID;
  - word 3 bit 27 as the priority.
  Descriptors are issued in ring order. Word w of slot s sits at register address 128 + 8*s + w.
- R3: The byte count presented on the request is the descriptor's word 6 rounded up to the next power of two. A value that is already a power of two passes unchanged.
- R4: Writing the mode register (address 0) with bit 1 set advances the enqueue pointer (address 3) by 32 bytes. Bit 1 always reads back as 0.
- R5: While mode bit 0 is clear, no new request is started, even with descriptors pending. Setting it starts processing.
- R6: Once raised, req_valid_o and the request fields hold steady until req_ready_i is seen. After acceptance, valid drops.
- R7: A completion pulse on xfer_done_i advances the dequeue pointer (address 2) by 32 bytes. The pointer wraps to 0 after the last entry of the programmed ring length. The size code sits at mode bits [15:12].
- R8: An enqueue step that makes the ring full sets status bit 0x10. An enqueue request while the ring is already full sets status bit 0x20 and leaves the enqueue pointer unchanged.
- R9: On completion, status bit 0x02 is set only if descriptor word 3 bit 29 was set. Status bit 0x80 is set if xfer_err_i accompanied the done pulse.
- R10: Writing 1 to status bits 0x80, 0x20, 0x10, 0x02 or 0x01 (address 1) clears them. Writing 0 leaves them.
- R11: irq_o is high exactly when some status flag is set whose enable bit in mode bits [23:16] (same bit position) is set. The queue-empty flag 0x01 is not enabled after reset.
- R12: A completion that leaves the ring empty sets status bit 0x01.
- R13: Pointer register writes take effect only while the unit is off and no transfer is in flight. The written value is bits [8:5] taken as a slot, masked to the ring length.
- R14: Status bit 0x04 reads 1 while a descriptor is issued or awaiting completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Register/descriptor write strobe |
| sw_addr | input | 8 | Word address: below 128 registers, from 128 descriptor store |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data for sw_addr |
| req_valid_o | output | 1 | Transfer request valid |
| req_ready_i | input | 1 | Transfer request accepted |
| req_src_o | output | 32 | Source buffer address |
| req_dest_o | output | 16 | Destination ID |
| req_mbox_o | output | 2 | Mailbox number |
| req_prio_o | output | 1 | Priority bit |
| req_bytes_o | output | 32 | Power-of-two byte count |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_err_i | input | 1 | Transfer failed, qualified by done |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- request stability while unaccepted;
- the power-of-two byte count;
- silence of the request port while the unit is off and idle;
- the busy flag during a request;
- dequeue motion only after completion;
- an unchanged enqueue slot when overflow is flagged;
- a quiet interrupt with no flags set.

Field ordering across a wrapped ring and the exact flag combinations after full, overflow, error and empty events depend on multi-step sequences. The same holds for the masking of the queue-empty interrupt and the refusal of pointer writes while enabled. Only the bench scenarios, with their scoreboard of expected requests, can show these.

// File: rtl/obr_pkg.sv
package obr_pkg;
    localparam int DEST_W      = 16;
    localparam int W_SRC       = 1;
    localparam int W_MBOX      = 2;
    localparam int W_ATTR      = 3;
    localparam int W_CNT       = 6;
    localparam int AT_DEST_LSB = 2;
    localparam int AT_PRIO     = 27;
    localparam int AT_EOM      = 29;
    localparam int MD_EN       = 0;
    localparam int MD_BUMP     = 1;
    localparam int MD_SIZE_LSB = 12;
    localparam int MD_SIZE_W   = 4;
    localparam int MD_IE_LSB   = 16;
    localparam int SB_QE       = 0;
    localparam int SB_EOM      = 1;
    localparam int SB_BUSY     = 2;
    localparam int SB_QF       = 4;
    localparam int SB_QO       = 5;
    localparam int SB_TE       = 7;
    localparam logic [7:0] STICKY_MASK = 8'hB3;
    localparam logic [7:0] IE_RESET    = 8'hB2;

    typedef enum logic [1:0] {XS_IDLE, XS_ISSUE, XS_WAIT} xfer_state_e;

    typedef struct packed {
        logic [31:0]       src;
        logic [1:0]        mbox;
        logic [DEST_W-1:0] dest;
        logic              prio;
        logic              eom;
        logic [31:0]       bytes;
    } desc_t;

    typedef struct packed {
        xfer_state_e state;
        desc_t       desc;
    } xfer_regs_t;

    // Smallest power of two not below n; 0 and 1 both give 1.
    function automatic logic [31:0] pow2_ceil(input logic [31:0] n);
        logic [31:0] r;
        r = 32'd1;
        for (int i = 0; i < 31; i++) begin
            if (r < n) r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/obr_desc_ram.sv
module obr_desc_ram
    import obr_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int SW   = $clog2(SLOTS),
    localparam int IW   = SW + 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] raddr,
    output logic [31:0]   rdata,
    input  logic [SW-1:0] fetch_slot,
    output desc_t         fetch_o
);
    logic [31:0] mem [SLOTS*8];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    logic [31:0] w_src, w_mbox, w_attr, w_cnt;

    always_comb begin
        rdata         = mem[raddr];
        w_src         = mem[{fetch_slot, 3'(W_SRC)}];
        w_mbox        = mem[{fetch_slot, 3'(W_MBOX)}];
        w_attr        = mem[{fetch_slot, 3'(W_ATTR)}];
        w_cnt         = mem[{fetch_slot, 3'(W_CNT)}];
        fetch_o.src   = w_src;
        fetch_o.mbox  = w_mbox[1:0];
        fetch_o.dest  = w_attr[AT_DEST_LSB +: DEST_W];
        fetch_o.prio  = w_attr[AT_PRIO];
        fetch_o.eom   = w_attr[AT_EOM];
        fetch_o.bytes = w_cnt;
    end
endmodule

// File: rtl/obr_ring_ptrs.sv
module obr_ring_ptrs #(
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] size_mask,
    input  logic          bump,
    input  logic          advance,
    input  logic          wr_enq,
    input  logic          wr_deq,
    input  logic [SW-1:0] wr_slot,
    output logic [SW-1:0] enq_o,
    output logic [SW-1:0] deq_o,
    output logic          empty_o,
    output logic          ovf_ev,
    output logic          full_ev,
    output logic          empty_ev
);
    typedef struct packed {
        logic [SW-1:0] enq;
        logic [SW-1:0] deq;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [SW-1:0] enq_step, next_enq_step;
    logic full_now, full_next;

    always_comb begin
        ptr_d         = ptr_q;
        enq_step      = (ptr_q.enq + 1'b1) & size_mask;
        full_now      = (enq_step == ptr_q.deq);
        ovf_ev        = bump && full_now;
        if (wr_enq)                ptr_d.enq = wr_slot & size_mask;
        else if (bump && !full_now) ptr_d.enq = enq_step;
        if (wr_deq)                ptr_d.deq = wr_slot & size_mask;
        else if (advance)          ptr_d.deq = (ptr_q.deq + 1'b1) & size_mask;
        next_enq_step = (ptr_d.enq + 1'b1) & size_mask;
        full_next     = (next_enq_step == ptr_d.deq);
        full_ev       = bump && !full_now && full_next;
        empty_ev      = advance && (ptr_d.enq == ptr_d.deq);
        enq_o         = ptr_q.enq;
        deq_o         = ptr_q.deq;
        empty_o       = (ptr_q.enq == ptr_q.deq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/obr_xfer_fsm.sv
module obr_xfer_fsm
    import obr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  pending,
    input  desc_t fetch_i,
    input  logic  req_ready,
    input  logic  done,
    input  logic  err,
    output logic  req_valid,
    output desc_t req_desc,
    output logic  advance,
    output logic  eom_ev,
    output logic  te_ev,
    output logic  busy
);
    xfer_regs_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        advance = 1'b0;
        eom_ev  = 1'b0;
        te_ev   = 1'b0;
        unique case (st_q.state)
            XS_IDLE: begin
                if (enable && pending) begin
                    st_d.desc       = fetch_i;
                    st_d.desc.bytes = pow2_ceil(fetch_i.bytes);
                    st_d.state      = XS_ISSUE;
                end
            end
            XS_ISSUE: begin
                if (req_ready) st_d.state = XS_WAIT;
            end
            XS_WAIT: begin
                if (done) begin
                    advance    = 1'b1;
                    eom_ev     = st_q.desc.eom;
                    te_ev      = err;
                    st_d.state = XS_IDLE;
                end
            end
            default: st_d.state = XS_IDLE;
        endcase
        req_valid = (st_q.state == XS_ISSUE);
        req_desc  = st_q.desc;
        busy      = (st_q.state != XS_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: XS_IDLE, desc: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/obmsg_ring_engine.sv
module obmsg_ring_engine
    import obr_pkg::*;
#(
    parameter int  MAX_ENTRIES = 16,
    localparam int SLOT_W      = $clog2(MAX_ENTRIES),
    localparam int RAM_WORDS   = MAX_ENTRIES * 8,
    localparam int AW          = $clog2(RAM_WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_addr,
    input  logic [31:0]       sw_wdata,
    output logic [31:0]       sw_rdata,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [31:0]       req_src_o,
    output logic [DEST_W-1:0] req_dest_o,
    output logic [1:0]        req_mbox_o,
    output logic              req_prio_o,
    output logic [31:0]       req_bytes_o,
    input  logic              xfer_done_i,
    input  logic              xfer_err_i,
    output logic              irq_o
);
    typedef struct packed {
        logic                 en;
        logic [MD_SIZE_W-1:0] size_code;
        logic [7:0]           ie;
        logic [7:0]           flags;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SLOT_W-1:0] enq_slot, deq_slot, size_mask, wr_slot;
    logic              ring_empty, ovf_ev, full_ev, empty_ev;
    logic              advance, eom_ev, te_ev, busy;
    logic              reg_hit, wr_mode, wr_stat, wr_deq, wr_enq, bump, ram_we;
    logic              ptr_ok, ptr_wr_deq, ptr_wr_enq;
    logic [31:0]       ram_rdata;
    logic [7:0]        set_bits, clr_bits, flags_q;
    logic              en_q;
    desc_t             fetch_desc, req_desc;
    int                lg;

    // Software decode and control-state next values
    always_comb begin
        reg_hit    = sw_we && !sw_addr[AW-1] && (sw_addr[AW-2:2] == '0);
        wr_mode    = reg_hit && (sw_addr[1:0] == 2'd0);
        wr_stat    = reg_hit && (sw_addr[1:0] == 2'd1);
        wr_deq     = reg_hit && (sw_addr[1:0] == 2'd2);
        wr_enq     = reg_hit && (sw_addr[1:0] == 2'd3);
        ram_we     = sw_we && sw_addr[AW-1];
        bump       = wr_mode && sw_wdata[MD_BUMP];
        ptr_ok     = !ctl_q.en && !busy;
        ptr_wr_deq = wr_deq && ptr_ok;
        ptr_wr_enq = wr_enq && ptr_ok;
        wr_slot    = sw_wdata[5 +: SLOT_W];

        lg = int'(ctl_q.size_code) + 1;
        if (lg > SLOT_W) lg = SLOT_W;
        size_mask = SLOT_W'((1 << lg) - 1);

        set_bits         = '0;
        set_bits[SB_TE]  = te_ev;
        set_bits[SB_QO]  = ovf_ev;
        set_bits[SB_QF]  = full_ev;
        set_bits[SB_EOM] = eom_ev;
        set_bits[SB_QE]  = empty_ev;
        clr_bits         = wr_stat ? (sw_wdata[7:0] & STICKY_MASK) : 8'h00;

        ctl_d       = ctl_q;
        ctl_d.flags = (ctl_q.flags & ~clr_bits) | set_bits;
        if (wr_mode) begin
            ctl_d.en        = sw_wdata[MD_EN];
            ctl_d.size_code = sw_wdata[MD_SIZE_LSB +: MD_SIZE_W];
            ctl_d.ie        = sw_wdata[MD_IE_LSB +: 8] & STICKY_MASK;
        end
    end

    // Read mux
    always_comb begin
        sw_rdata = '0;
        if (sw_addr[AW-1]) begin
            sw_rdata = ram_rdata;
        end else if (sw_addr[AW-2:2] == '0) begin
            unique case (sw_addr[1:0])
                2'd0: begin
                    sw_rdata[MD_EN]                         = ctl_q.en;
                    sw_rdata[MD_SIZE_LSB +: MD_SIZE_W]      = ctl_q.size_code;
                    sw_rdata[MD_IE_LSB +: 8]                = ctl_q.ie;
                end
                2'd1: begin
                    sw_rdata[7:0]    = ctl_q.flags;
                    sw_rdata[SB_BUSY] = busy;
                end
                2'd2: sw_rdata = 32'({deq_slot, 5'b0});
                default: sw_rdata = 32'({enq_slot, 5'b0});
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{en: 1'b0, size_code: '0, ie: IE_RESET, flags: '0};
        else        ctl_q <= ctl_d;
    end

    obr_desc_ram #(.SLOTS(MAX_ENTRIES)) u_ram (
        .clk        (clk),
        .we         (ram_we),
        .waddr      (sw_addr[AW-2:0]),
        .wdata      (sw_wdata),
        .raddr      (sw_addr[AW-2:0]),
        .rdata      (ram_rdata),
        .fetch_slot (deq_slot),
        .fetch_o    (fetch_desc)
    );

    obr_ring_ptrs #(.SW(SLOT_W)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_mask (size_mask),
        .bump      (bump),
        .advance   (advance),
        .wr_enq    (ptr_wr_enq),
        .wr_deq    (ptr_wr_deq),
        .wr_slot   (wr_slot),
        .enq_o     (enq_slot),
        .deq_o     (deq_slot),
        .empty_o   (ring_empty),
        .ovf_ev    (ovf_ev),
        .full_ev   (full_ev),
        .empty_ev  (empty_ev)
    );

    obr_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctl_q.en),
        .pending   (!ring_empty),
        .fetch_i   (fetch_desc),
        .req_ready (req_ready_i),
        .done      (xfer_done_i),
        .err       (xfer_err_i),
        .req_valid (req_valid_o),
        .req_desc  (req_desc),
        .advance   (advance),
        .eom_ev    (eom_ev),
        .te_ev     (te_ev),
        .busy      (busy)
    );

    assign req_src_o   = req_desc.src;
    assign req_dest_o  = req_desc.dest;
    assign req_mbox_o  = req_desc.mbox;
    assign req_prio_o  = req_desc.prio;
    assign req_bytes_o = req_desc.bytes;
    assign irq_o       = |(ctl_q.flags & ctl_q.ie);
    assign flags_q     = ctl_q.flags;
    assign en_q        = ctl_q.en;
endmodule

// File: rtl/obr_checker.sv
module obr_checker #(
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [31:0]   req_src,
    input logic [31:0]   req_bytes,
    input logic          irq,
    input logic [7:0]    flags,
    input logic          en,
    input logic          busy,
    input logic [SW-1:0] enq_slot,
    input logic [SW-1:0] deq_slot,
    input logic          ptr_wr_deq,
    input logic          xfer_done
);
    p_bytes_pow2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(req_bytes) == 1));

    p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !req_valid);

    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_bytes)));

    p_deq_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((deq_slot != $past(deq_slot)) && !$past(ptr_wr_deq)) |-> $past(xfer_done));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[5]) |-> $stable(enq_slot));

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 8'h00) |-> !irq);

    p_busy_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);
endmodule

bind obmsg_ring_engine obr_checker #(.SW(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid_o),
    .req_ready  (req_ready_i),
    .req_src    (req_src_o),
    .req_bytes  (req_bytes_o),
    .irq        (irq_o),
    .flags      (flags_q),
    .en         (en_q),
    .busy       (busy),
    .enq_slot   (enq_slot),
    .deq_slot   (deq_slot),
    .ptr_wr_deq (ptr_wr_deq),
    .xfer_done  (xfer_done_i)
);

// File: tb/obmsg_ring_engine_test.sv
module obmsg_ring_engine_test;
    typedef struct packed {
        logic [31:0] src;
        logic [15:0] dest;
        logic [1:0]  mbox;
        logic        prio;
        logic [31:0] bytes;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_we = 1'b0;
    logic [7:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        req_valid_o, req_ready_i = 1'b0;
    logic [31:0] req_src_o, req_bytes_o;
    logic [15:0] req_dest_o;
    logic [1:0]  req_mbox_o;
    logic        req_prio_o;
    logic        xfer_done_i = 1'b0, xfer_err_i = 1'b0;
    logic        irq_o;

    int   errors = 0;
    int   checks = 0;
    logic auto_resp = 1'b1;
    logic inj_err = 1'b0;
    logic finished = 1'b0;
    int   accepted = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    obmsg_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_src_o(req_src_o), .req_dest_o(req_dest_o),
        .req_mbox_o(req_mbox_o), .req_prio_o(req_prio_o), .req_bytes_o(req_bytes_o),
        .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic sw_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sw_addr = a;
        #1 d = sw_rdata;
    endtask

    function automatic logic [31:0] mode_word(input logic en, input logic bump);
        return 32'h00B2_1000 | {30'b0, bump, en};
    endfunction

    // Driver: fill one descriptor and push the request it must produce
    task automatic put_desc(input int slot, input logic [31:0] src, input logic [1:0] mbox,
                            input logic [15:0] dest, input logic prio, input logic eom,
                            input logic [31:0] cnt, input logic [31:0] exp_bytes);
        logic [7:0] base;
        exp_t e;
        base = 8'(128 + slot * 8);
        sw_write(base + 8'd1, src);
        sw_write(base + 8'd2, {30'b0, mbox});
        sw_write(base + 8'd3, {2'b0, eom, 1'b0, prio, 9'b0, dest, 2'b0});
        sw_write(base + 8'd6, cnt);
        e = '{src: src, dest: dest, mbox: mbox, prio: prio, bytes: exp_bytes};
        exp_q.push_back(e);
    endtask

    task automatic wait_deq(input logic [31:0] target, input string req);
        logic [31:0] v;
        bit hit;
        hit = 0;
        for (int i = 0; i < 300; i++) begin
            sw_read(8'd2, v);
            if (v == target) begin hit = 1; break; end
        end
        check(req, v, target);
        repeat (2) @(negedge clk);
        if (!hit) $display("  (timeout waiting on dequeue pointer)");
    endtask

    // Responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (auto_resp && req_valid_o) begin
                logic [31:0] src0;
                exp_t e;
                src0 = req_src_o;
                repeat (2) begin
                    @(negedge clk);
                    check("R6 valid held", {31'b0, req_valid_o}, 32'd1);
                    check("R6 source stable", req_src_o, src0);
                end
                req_ready_i = 1'b1;
                accepted++;
                if (exp_q.size() == 0) begin
                    check("R2 unexpected request", req_src_o, 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    check("R2 source", req_src_o, e.src);
                    check("R2 dest", {16'b0, req_dest_o}, {16'b0, e.dest});
                    check("R2 mailbox", {30'b0, req_mbox_o}, {30'b0, e.mbox});
                    check("R2 priority", {31'b0, req_prio_o}, {31'b0, e.prio});
                    check("R3 byte count", req_bytes_o, e.bytes);
                end
                @(negedge clk);
                req_ready_i = 1'b0;
                check("R6 valid drops after accept", {31'b0, req_valid_o}, 32'd0);
                @(negedge clk);
                xfer_done_i = 1'b1;
                xfer_err_i  = inj_err;
                @(negedge clk);
                xfer_done_i = 1'b0;
                xfer_err_i  = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        sw_read(8'd0, v); check("R1 mode", v, 32'h00B2_0000);
        sw_read(8'd1, v); check("R1 status", v, 32'd0);
        sw_read(8'd2, v); check("R1 deq", v, 32'd0);
        sw_read(8'd3, v); check("R1 enq", v, 32'd0);
        check("R1 valid", {31'b0, req_valid_o}, 32'd0);
        check("R1 irq", {31'b0, irq_o}, 32'd0);

        // Ring of 4 entries (code 1), unit off: R4, R5
        sw_write(8'd0, mode_word(1'b0, 1'b0));
        put_desc(0, 32'h1000_0040, 2'd2, 16'h1234, 1'b1, 1'b1, 32'd100, 32'd128);
        sw_write(8'd0, mode_word(1'b0, 1'b1));
        sw_read(8'd3, v); check("R4 enq step", v, 32'h20);
        sw_read(8'd0, v); check("R4 bump reads 0", v & 32'h2, 32'd0);
        repeat (10) @(negedge clk);
        check("R5 no request while off", {31'b0, req_valid_o}, 32'd0);
        sw_read(8'd2, v); check("R5 deq unchanged", v, 32'd0);
        sw_write(8'd0, mode_word(1'b1, 1'b0));
        wait_deq(32'h20, "R7 deq after done");
        check("R5 started after enable", accepted, 1);
        sw_read(8'd1, v); check("R9 eom and R12 empty flags", v, 32'h03);
        check("R11 irq on eom", {31'b0, irq_o}, 32'd1);
        sw_write(8'd1, 32'h02);
        sw_read(8'd1, v); check("R10 eom cleared", v, 32'h01);
        check("R11 queue-empty masked", {31'b0, irq_o}, 32'd0);
        sw_write(8'd1, 32'h01);
        sw_read(8'd1, v); check("R10 empty cleared", v, 32'd0);

        // No end-of-message request, large count
        put_desc(1, 32'h2000_0000, 2'd3, 16'hBEEF, 1'b0, 1'b0, 32'd1000, 32'd1024);
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        wait_deq(32'h40, "R7 deq second");
        sw_read(8'd1, v); check("R9 no eom flag", v, 32'h01);
        sw_write(8'd1, 32'hB3);

        // Transfer error, exact power of two count
        inj_err = 1'b1;
        put_desc(2, 32'h3000_0100, 2'd1, 16'h0001, 1'b0, 1'b0, 32'd64, 32'd64);
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        wait_deq(32'h60, "R7 deq third");
        inj_err = 1'b0;
        sw_read(8'd1, v); check("R9 error flag", v, 32'h81);
        check("R11 irq on error", {31'b0, irq_o}, 32'd1);
        sw_write(8'd1, 32'hB3);
        check("R11 irq cleared", {31'b0, irq_o}, 32'd0);

        // Fill with responder paused: R8, R14, then wrap R7
        auto_resp = 1'b0;
        put_desc(3, 32'h4000_0000, 2'd0, 16'h0A0A, 1'b1, 1'b0, 32'd8, 32'd8);
        put_desc(0, 32'h5000_0000, 2'd1, 16'h0B0B, 1'b0, 1'b0, 32'd9, 32'd16);
        put_desc(1, 32'h6000_0000, 2'd2, 16'h0C0C, 1'b1, 1'b0, 32'd0, 32'd1);
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        sw_read(8'd1, v); check("R8 not yet full", v & 32'h10, 32'd0);
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        sw_read(8'd1, v); check("R8 full flag and R14 busy", v, 32'h14);
        sw_read(8'd3, v); check("R8 enq at full", v, 32'h40);
        sw_write(8'd0, mode_word(1'b1, 1'b1));
        sw_read(8'd3, v); check("R8 enq held on overflow", v, 32'h40);
        sw_read(8'd1, v); check("R8 overflow flag", v, 32'h34);
        check("R6 request still offered", {31'b0, req_valid_o}, 32'd1);
        auto_resp = 1'b1;
        wait_deq(32'h40, "R7 deq wraps through 0");
        check("R2 all requests consumed", exp_q.size(), 0);
        sw_read(8'd1, v); check("R12 empty after drain", v & 32'h05, 32'h01);
        sw_write(8'd1, 32'hB3);
        sw_read(8'd1, v); check("R10 all cleared", v, 32'd0);

        // Pointer writes: R13
        sw_write(8'd2, 32'h20);
        sw_read(8'd2, v); check("R13 write ignored while on", v, 32'h40);
        sw_write(8'd0, mode_word(1'b0, 1'b0));
        sw_write(8'd2, 32'h60);
        sw_read(8'd2, v); check("R13 deq written while off", v, 32'h60);
        sw_write(8'd3, 32'h1E0);
        sw_read(8'd3, v); check("R13 enq masked to ring", v, 32'h60);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule